// File: doc/BRIEF.md
# Memory-operation ordering queue

This block holds the memory operations a core has dispatched but not yet finished, and each cycle it chooses at most one of them to send to the memory pipeline. Every operation is tagged at dispatch from three flags (may read memory, may write memory, has side effects) as a load, a store, a load barrier, a store barrier or a full barrier. Each tag belongs to one of two capacity pools, the load pool or the store pool, and a full barrier belongs to both. The order in which operations are released depends only on their age and their tag, never on addresses.

Entries are written in dispatch order into a circular buffer. An entry's age is its distance from the head pointer. Each cycle a scan from oldest to youngest finds every entry that is allowed to issue under the ordering rules, and the oldest of these is granted. A switch states that loads and stores never overlap; when it is set, loads may move ahead of older stores. Ordinary operations leave the queue after the memory side reports that they have completed. A barrier counts as complete as soon as it is granted. Entries leave strictly from the head, in order.

Top module: `memop_order_q`

## Requirements
- R1: A store (tag store or store barrier) is never granted while any older entry of any tag has not yet been granted.
- R2: A load may be granted ahead of an older store that has not been granted only while `no_alias` is 1. With `no_alias` at 0 it waits until every older store and store barrier has been granted.
- R3: Tags come from the flags as follows. Read and side effect gives a load barrier. Write and side effect gives a store barrier. All three flags give a full barrier. Read alone gives a load. Write, with or without read, gives a store. `gnt_kind` encodes load=0, store=1, load barrier=2, store barrier=3, full barrier=4. A full barrier is granted only when no older entry is present. A store barrier is granted only when no older store-pool entry is present. A load barrier is granted only when no older load-pool entry is present.
- R4: A load or store younger than a load barrier or full barrier that has not yet been granted is not granted. A store younger than a store barrier that has not yet been granted is not granted.
- R5: At most one grant is made per cycle, and only while `iss_ready` was high at the clock edge. It goes to the oldest eligible entry. `gnt_*` reflects the queue state before that edge, so an entry allocated at edge N can be granted at edge N+1 at the earliest. An entry is granted only once.
- R6: The store pool holds at most `SQ_SIZE` entries and the load pool holds at most `LQ_SIZE` entries. A size of 0 means `DEPTH`. The whole queue holds `DEPTH` entries. `alloc_rdy` is high only when the offered operation fits.
- R7: An allocation that sets neither the read flag nor the write flag takes no entry, and `alloc_tag` does not advance.
- R8: Tags are entry indices handed out in dispatch order from 0 after reset, wrapping at `DEPTH`. A completion on `cmp_tag` marks a granted entry complete. Complete entries leave from the head, one per cycle, in order, and free their space.
- R9: After reset the queue is empty, `gnt_vld` is 0, `alloc_tag` is 0 and `alloc_rdy` is 1.
- R10: A barrier is complete at its grant and leaves the queue with no completion input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| no_alias | input | 1 | 1: loads may pass older stores |
| alloc_vld | input | 1 | Dispatch offers an operation |
| alloc_mayld | input | 1 | Operation may read memory |
| alloc_mayst | input | 1 | Operation may write memory |
| alloc_side | input | 1 | Operation has side effects |
| alloc_rdy | output | 1 | Offered operation fits in the queue |
| alloc_tag | output | $clog2(DEPTH) | Tag the offered operation receives |
| iss_ready | input | 1 | Memory pipeline accepts a grant this cycle |
| gnt_vld | output | 1 | A grant was made at the last edge |
| gnt_tag | output | $clog2(DEPTH) | Tag of the granted entry |
| gnt_kind | output | 3 | Tag class of the granted entry |
| cmp_vld | input | 1 | Completion report |
| cmp_tag | input | $clog2(DEPTH) | Entry that completed |

## Verification
Allocation takes effect at the clock edge where it is offered. The grant for that entry shows at the next edge at the earliest, so the bench samples `gnt_vld` at the falling edge after each rising edge and confirms that nothing appears one cycle early. A completion marks the entry at one edge and the entry retires at the following edge. Checks that depend on freed space or on a barrier reaching the head therefore wait two edges after the completion. `alloc_rdy` depends only on the offered flags and on registered counts, so it is sampled a moment after the flags change, between edges.

// File: rtl/memop_order_pkg.sv
package memop_order_pkg;

  typedef enum logic [2:0] {
    K_LOAD  = 3'd0,
    K_STORE = 3'd1,
    K_LBAR  = 3'd2,
    K_SBAR  = 3'd3,
    K_FBAR  = 3'd4,
    K_NONE  = 3'd7
  } op_kind_e;

  function automatic op_kind_e classify(input logic rd, input logic wr, input logic se);
    if (rd && wr && se) return K_FBAR;
    if (rd && se && !wr) return K_LBAR;
    if (wr && se) return K_SBAR;
    if (wr) return K_STORE;
    if (rd) return K_LOAD;
    return K_NONE;
  endfunction

  function automatic logic in_ldq(input op_kind_e k);
    return (k == K_LOAD) || (k == K_LBAR) || (k == K_FBAR);
  endfunction

  function automatic logic in_stq(input op_kind_e k);
    return (k == K_STORE) || (k == K_SBAR) || (k == K_FBAR);
  endfunction

  function automatic logic is_barrier(input op_kind_e k);
    return (k == K_LBAR) || (k == K_SBAR) || (k == K_FBAR);
  endfunction

endpackage

// File: rtl/memop_cap.sv
module memop_cap #(
  parameter int DEPTH   = 8,
  parameter int LQ_SIZE = 0,
  parameter int SQ_SIZE = 4,
  parameter int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_any,
  input  logic          add_ld,
  input  logic          add_st,
  input  logic          sub_any,
  input  logic          sub_ld,
  input  logic          sub_st,
  input  logic          offer_ld,
  input  logic          offer_st,
  output logic          room,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] ld_cnt,
  output logic [CW-1:0] st_cnt
);
  localparam int LQ_EFF = (LQ_SIZE == 0) ? DEPTH : LQ_SIZE;
  localparam int SQ_EFF = (SQ_SIZE == 0) ? DEPTH : SQ_SIZE;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ    <= '0;
      ld_cnt <= '0;
      st_cnt <= '0;
    end else begin
      occ    <= occ + CW'(add_any) - CW'(sub_any);
      ld_cnt <= ld_cnt + CW'(add_ld) - CW'(sub_ld);
      st_cnt <= st_cnt + CW'(add_st) - CW'(sub_st);
    end
  end

  always_comb begin
    room = (occ < CW'(DEPTH));
    if (offer_ld && !(ld_cnt < CW'(LQ_EFF))) room = 1'b0;
    if (offer_st && !(st_cnt < CW'(SQ_EFF))) room = 1'b0;
  end
endmodule

// File: rtl/memop_scan.sv
module memop_scan
  import memop_order_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]           head,
  input  logic [DEPTH-1:0]        valid,
  input  logic [DEPTH-1:0]        issued,
  input  logic [DEPTH-1:0][2:0]   kind,
  input  logic                    no_alias,
  output logic                    pick_vld,
  output logic [IW-1:0]           pick_idx
);
  always_comb begin
    logic any_u, any_v, ld_u, ldv, stv, st_u, barl_u, ldst;
    logic u, v, ld_ok, elig;
    logic [IW-1:0] idx;
    op_kind_e kd;
    any_u = 1'b0; any_v = 1'b0; ld_u = 1'b0; ldv = 1'b0; stv = 1'b0;
    st_u = 1'b0; barl_u = 1'b0; ldst = 1'b0;
    u = 1'b0; v = 1'b0; ld_ok = 1'b0; elig = 1'b0; idx = '0; kd = K_NONE;
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx   = head + IW'(k);
      kd    = op_kind_e'(kind[idx]);
      v     = valid[idx];
      u     = v & ~issued[idx];
      // a load is held by an older unissued load barrier, by an older unissued
      // store when overlap is possible, or by a store/barrier sitting between
      // it and an older unissued load
      ld_ok = ~barl_u & (no_alias | ~st_u) & ~ldst;
      case (kd)
        K_LOAD:  elig = ld_ok;
        K_STORE: elig = ~any_u;
        K_LBAR:  elig = ld_ok & ~ldv;
        K_SBAR:  elig = ~any_u & ~stv;
        K_FBAR:  elig = ~any_v;
        default: elig = 1'b0;
      endcase
      if (u && elig && !pick_vld) begin
        pick_vld = 1'b1;
        pick_idx = idx;
      end
      if (u && ld_u && (kd == K_STORE || is_barrier(kd))) ldst = 1'b1;
      if (u) any_u = 1'b1;
      if (u && in_ldq(kd)) ld_u = 1'b1;
      if (u && (kd == K_LBAR || kd == K_FBAR)) barl_u = 1'b1;
      if (u && (kd == K_STORE || kd == K_SBAR)) st_u = 1'b1;
      if (v) any_v = 1'b1;
      if (v && in_ldq(kd)) ldv = 1'b1;
      if (v && in_stq(kd)) stv = 1'b1;
    end
  end
endmodule

// File: rtl/memop_order_q.sv
module memop_order_q
  import memop_order_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int LQ_SIZE = 0,
  parameter int SQ_SIZE = 4,
  parameter int IW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          no_alias,
  input  logic          alloc_vld,
  input  logic          alloc_mayld,
  input  logic          alloc_mayst,
  input  logic          alloc_side,
  output logic          alloc_rdy,
  output logic [IW-1:0] alloc_tag,
  input  logic          iss_ready,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_tag,
  output logic [2:0]    gnt_kind,
  input  logic          cmp_vld,
  input  logic [IW-1:0] cmp_tag
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0]         head, tail;
  logic [DEPTH-1:0]      valid_q, issued_q, done_q;
  logic [DEPTH-1:0][2:0] kind_q;
  logic [CW-1:0]         occ, ld_cnt, st_cnt;

  op_kind_e alloc_k, head_k;
  logic     room, alloc_fire, ret_fire, pick_vld, do_grant;
  logic [IW-1:0] pick_idx;

  assign alloc_k    = classify(alloc_mayld, alloc_mayst, alloc_side);
  assign alloc_fire = alloc_vld & (alloc_k != K_NONE) & room;
  assign alloc_rdy  = room;
  assign alloc_tag  = tail;
  assign head_k     = op_kind_e'(kind_q[head]);
  assign ret_fire   = valid_q[head] & done_q[head];
  assign do_grant   = iss_ready & pick_vld;

  memop_cap #(.DEPTH(DEPTH), .LQ_SIZE(LQ_SIZE), .SQ_SIZE(SQ_SIZE), .CW(CW)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .add_any  (alloc_fire),
    .add_ld   (alloc_fire & in_ldq(alloc_k)),
    .add_st   (alloc_fire & in_stq(alloc_k)),
    .sub_any  (ret_fire),
    .sub_ld   (ret_fire & in_ldq(head_k)),
    .sub_st   (ret_fire & in_stq(head_k)),
    .offer_ld (in_ldq(alloc_k)),
    .offer_st (in_stq(alloc_k)),
    .room     (room),
    .occ      (occ),
    .ld_cnt   (ld_cnt),
    .st_cnt   (st_cnt)
  );

  memop_scan #(.DEPTH(DEPTH), .IW(IW)) u_scan (
    .head     (head),
    .valid    (valid_q),
    .issued   (issued_q),
    .kind     (kind_q),
    .no_alias (no_alias),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  // tag storage: written only at allocation, no reset needed
  always_ff @(posedge clk) begin
    if (alloc_fire) kind_q[tail] <= alloc_k;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      tail     <= '0;
      valid_q  <= '0;
      issued_q <= '0;
      done_q   <= '0;
      gnt_vld  <= 1'b0;
      gnt_tag  <= '0;
      gnt_kind <= '0;
    end else begin
      if (alloc_fire) begin
        valid_q[tail]  <= 1'b1;
        issued_q[tail] <= 1'b0;
        done_q[tail]   <= 1'b0;
        tail           <= tail + 1'b1;
      end
      if (ret_fire) begin
        valid_q[head] <= 1'b0;
        head          <= head + 1'b1;
      end
      gnt_vld <= do_grant;
      if (do_grant) begin
        issued_q[pick_idx] <= 1'b1;
        gnt_tag            <= pick_idx;
        gnt_kind           <= kind_q[pick_idx];
        if (is_barrier(op_kind_e'(kind_q[pick_idx]))) done_q[pick_idx] <= 1'b1;
      end
      if (cmp_vld && valid_q[cmp_tag] && issued_q[cmp_tag]) done_q[cmp_tag] <= 1'b1;
    end
  end
endmodule

// File: rtl/memop_order_q_chk.sv
module memop_order_q_chk #(
  parameter int DEPTH   = 8,
  parameter int LQ_SIZE = 0,
  parameter int SQ_SIZE = 4,
  parameter int IW      = $clog2(DEPTH),
  parameter int CW      = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_vld,
  input logic          alloc_mayld,
  input logic          alloc_mayst,
  input logic [IW-1:0] alloc_tag,
  input logic          iss_ready,
  input logic          gnt_vld,
  input logic [IW-1:0] gnt_tag,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] ld_cnt,
  input logic [CW-1:0] st_cnt
);
  localparam int LQ_EFF = (LQ_SIZE == 0) ? DEPTH : LQ_SIZE;
  localparam int SQ_EFF = (SQ_SIZE == 0) ? DEPTH : SQ_SIZE;

  p_grant_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> $past(iss_ready));

  p_no_regrant_r5: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |=> !(gnt_vld && gnt_tag == $past(gnt_tag)));

  p_sq_cap_r6: assert property (@(posedge clk) disable iff (rst)
    st_cnt <= CW'(SQ_EFF));

  p_lq_cap_r6: assert property (@(posedge clk) disable iff (rst)
    ld_cnt <= CW'(LQ_EFF));

  p_occ_cap_r6: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (alloc_vld && !alloc_mayld && !alloc_mayst) |=> $stable(alloc_tag));
endmodule

bind memop_order_q memop_order_q_chk #(
  .DEPTH(DEPTH), .LQ_SIZE(LQ_SIZE), .SQ_SIZE(SQ_SIZE), .IW(IW), .CW(CW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .alloc_vld   (alloc_vld),
  .alloc_mayld (alloc_mayld),
  .alloc_mayst (alloc_mayst),
  .alloc_tag   (alloc_tag),
  .iss_ready   (iss_ready),
  .gnt_vld     (gnt_vld),
  .gnt_tag     (gnt_tag),
  .occ         (occ),
  .ld_cnt      (ld_cnt),
  .st_cnt      (st_cnt)
);

// File: tb/memop_order_q_bench.sv
module memop_order_q_bench;
  localparam int DEPTH = 8;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic no_alias = 1'b1;
  logic alloc_vld = 1'b0, alloc_mayld = 1'b0, alloc_mayst = 1'b0, alloc_side = 1'b0;
  logic alloc_rdy;
  logic [IW-1:0] alloc_tag;
  logic iss_ready = 1'b0;
  logic gnt_vld;
  logic [IW-1:0] gnt_tag;
  logic [2:0] gnt_kind;
  logic cmp_vld = 1'b0;
  logic [IW-1:0] cmp_tag = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int got_n;
  int got_tag [16];
  int got_kind [16];

  always #2 clk = ~clk;

  memop_order_q #(.DEPTH(DEPTH), .LQ_SIZE(0), .SQ_SIZE(4)) u_memop_order_q (
    .clk(clk), .rst(rst), .no_alias(no_alias),
    .alloc_vld(alloc_vld), .alloc_mayld(alloc_mayld), .alloc_mayst(alloc_mayst),
    .alloc_side(alloc_side), .alloc_rdy(alloc_rdy), .alloc_tag(alloc_tag),
    .iss_ready(iss_ready), .gnt_vld(gnt_vld), .gnt_tag(gnt_tag), .gnt_kind(gnt_kind),
    .cmp_vld(cmp_vld), .cmp_tag(cmp_tag)
  );

  // row: {no_alias, kind0..kind3, grant count, tag0..tag3}
  // kinds: 0 load, 1 store, 2 load barrier, 3 store barrier, 4 full barrier
  localparam logic [27:0] ROWS [10] = '{
    {1'b1, 3'd1, 3'd3, 3'd0, 3'd1, 3'd2, 3'd0, 3'd2, 3'd0, 3'd0},
    {1'b0, 3'd1, 3'd3, 3'd0, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 3'd0, 3'd4, 3'd1, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 3'd4, 3'd0, 3'd1, 3'd0, 3'd4, 3'd0, 3'd1, 3'd2, 3'd3},
    {1'b1, 3'd0, 3'd2, 3'd0, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 3'd1, 3'd2, 3'd1, 3'd0, 3'd4, 3'd0, 3'd1, 3'd2, 3'd3},
    {1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd0, 3'd1, 3'd2, 3'd3},
    {1'b0, 3'd0, 3'd3, 3'd0, 3'd1, 3'd4, 3'd0, 3'd1, 3'd2, 3'd3},
    {1'b1, 3'd1, 3'd1, 3'd3, 3'd0, 3'd3, 3'd0, 3'd1, 3'd3, 3'd0},
    {1'b0, 3'd1, 3'd1, 3'd3, 3'd0, 3'd2, 3'd0, 3'd1, 3'd0, 3'd0}
  };
  localparam string ROW_REQ [10] = '{"R2", "R2", "R3", "R3", "R4", "R3",
                                     "R5", "R1", "R4", "R2"};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_flags(input int k);
    alloc_mayld = (k == 0) || (k == 2) || (k == 4);
    alloc_mayst = (k == 1) || (k == 3) || (k == 4);
    alloc_side  = (k >= 2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; iss_ready = 1'b0; alloc_vld = 1'b0; cmp_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic alloc(input int k);
    set_flags(k);
    alloc_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    alloc_vld = 1'b0;
  endtask

  task automatic collect(input int cycles);
    got_n = 0;
    iss_ready = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (gnt_vld && got_n < 16) begin
        got_tag[got_n]  = int'(gnt_tag);
        got_kind[got_n] = int'(gnt_kind);
        got_n++;
      end
    end
    iss_ready = 1'b0;
  endtask

  task automatic complete(input int t);
    cmp_tag = IW'(t);
    cmp_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmp_vld = 1'b0;
  endtask

  task automatic offer(input int k, input bit exp, input string req);
    set_flags(k);
    #1;
    chk(alloc_rdy == exp, req, int'(alloc_rdy), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    do_reset();
    set_flags(0);
    #1;
    chk(gnt_vld == 1'b0, "R9", int'(gnt_vld), 0);
    chk(alloc_tag == '0, "R9", int'(alloc_tag), 0);
    chk(alloc_rdy == 1'b1, "R9", int'(alloc_rdy), 1);

    // ordering table
    for (int r = 0; r < 10; r++) begin
      logic [27:0] row;
      int exp_n;
      row = ROWS[r];
      do_reset();
      no_alias = row[27];
      alloc(int'(row[26:24]));
      alloc(int'(row[23:21]));
      alloc(int'(row[20:18]));
      alloc(int'(row[17:15]));
      collect(6);
      exp_n = int'(row[14:12]);
      chk(got_n == exp_n, ROW_REQ[r], got_n, exp_n);
      for (int g = 0; g < 4; g++) begin
        int exp_t;
        exp_t = int'(row[11 - 3*g -: 3]);
        if (g < exp_n && g < got_n)
          chk(got_tag[g] == exp_t, ROW_REQ[r], got_tag[g], exp_t);
      end
    end
    no_alias = 1'b1;

    // R5: grant one cycle after the allocation edge
    do_reset();
    set_flags(0);
    alloc_vld = 1'b1;
    iss_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    alloc_vld = 1'b0;
    chk(gnt_vld == 1'b0, "R5", int'(gnt_vld), 0);
    @(posedge clk);
    @(negedge clk);
    chk(gnt_vld == 1'b1, "R5", int'(gnt_vld), 1);
    chk(gnt_tag == 3'd0, "R5", int'(gnt_tag), 0);
    iss_ready = 1'b0;

    // R3 / R8: full barrier waits for the older load to retire
    do_reset();
    alloc(0); alloc(4); alloc(1);
    collect(3);
    chk(got_n == 1, "R3", got_n, 1);
    complete(0);
    collect(4);
    chk(got_n == 2, "R8", got_n, 2);
    if (got_n == 2) begin
      chk(got_tag[0] == 1, "R3", got_tag[0], 1);
      chk(got_kind[0] == 4, "R3", got_kind[0], 4);
      chk(got_tag[1] == 2, "R1", got_tag[1], 2);
      chk(got_kind[1] == 1, "R3", got_kind[1], 1);
    end

    // R6: store pool limit of four
    do_reset();
    alloc(1); alloc(1); alloc(1); alloc(1);
    offer(1, 1'b0, "R6");
    offer(4, 1'b0, "R6");
    offer(0, 1'b1, "R6");

    // R6: load pool size 0 means DEPTH; R8: wrap and release
    do_reset();
    for (int i = 0; i < 8; i++) begin
      offer(0, 1'b1, "R6");
      alloc(0);
    end
    chk(alloc_tag == '0, "R8", int'(alloc_tag), 0);
    offer(0, 1'b0, "R6");
    collect(9);
    chk(got_n == 8, "R5", got_n, 8);
    complete(0);
    @(negedge clk);
    offer(0, 1'b1, "R8");

    // R7: no read or write flag takes no entry
    do_reset();
    alloc(0);
    alloc_mayld = 1'b0; alloc_mayst = 1'b0; alloc_side = 1'b0;
    alloc_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(alloc_tag == 3'd1, "R7", int'(alloc_tag), 1);
    alloc_side = 1'b1;
    @(posedge clk);
    @(negedge clk);
    alloc_vld = 1'b0;
    chk(alloc_tag == 3'd1, "R7", int'(alloc_tag), 1);
    alloc(1);
    chk(alloc_tag == 3'd2, "R7", int'(alloc_tag), 2);

    // R10: a barrier retires without a completion
    do_reset();
    alloc(4);
    for (int i = 0; i < 7; i++) alloc(0);
    offer(0, 1'b0, "R10");
    collect(1);
    chk(got_n == 1, "R10", got_n, 1);
    @(negedge clk);
    offer(0, 1'b1, "R10");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule